// File: doc/BRIEF.md
# Coalesced Interrupt Acknowledgement Tracker

This block watches one edge-triggered interrupt pin whose deliveries may reach several destinations at once. When a delivery completes, it stores which destinations accepted the interrupt, the vector each of them received, and how many acknowledgements (EOIs) are still owed. While any acknowledgement is owed, a fresh assertion on the pin is flagged as coalesced, so the surrounding logic can report that assertion as dropped instead of delivering it.

EOIs arrive tagged with the sending destination and the vector. An EOI only counts when that destination is still owed an acknowledgement for exactly that vector. A resync port lets each destination report its live pending state, and the tracker then adds or removes that destination. If the owed count would ever drop below zero, the tracker discards its state. It rebuilds the state from the live pending map of all destinations. Delivery itself happens outside this block.

Top module: `coal_eoi_tracker`

## Requirements
- R1: `coalesced_o` is high in the same cycle as `pin_assert_i` exactly when the owed count is above zero.
- R2: A delivery (`dlv_valid_i`) loads the owed count from `dlv_result_i`, a two's-complement value of CNT_W+1 bits. It records the `dlv_accept_i` map with `dlv_vector_i` for each accepted destination. A negative result loads a count of 0 and an empty map. The new count shows on `pending_o` one cycle later.
- R3: An EOI whose destination bit is set and whose vector equals the one recorded for that destination clears the bit and lowers the count by one in the next cycle.
- R4: An EOI whose vector differs from the recorded one changes neither the count nor the map.
- R5: An EOI from a destination whose bit is clear is ignored.
- R6: If a matching EOI or a resync-clear arrives while the count is 0, the map is rebuilt from `live_pend_i`. Each rebuilt destination records `pin_vector_i`, and the count becomes the number of set bits in `live_pend_i`.
- R7: `clr_i` empties the map and zeroes the count in the next cycle.
- R8: A resync reporting pending for a destination whose bit is clear sets the bit, records `pin_vector_i` and raises the count by one. A resync that agrees with the stored bit changes nothing.
- R9: A resync reporting not-pending for a destination whose bit is set clears the bit and lowers the count by one.
- R10: Only one event acts per cycle, chosen in this priority order: clear, then delivery, then EOI, then resync.
- R11: After reset the count is 0 and the map is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_assert_i | input | 1 | New assertion on the tracked pin this cycle |
| clr_i | input | 1 | Clear tracking state |
| dlv_valid_i | input | 1 | Delivery result present |
| dlv_result_i | input | CNT_W+1 | Signed number of destinations reached, negative on failure |
| dlv_accept_i | input | NUM_DEST | Destinations that accepted the delivery |
| dlv_vector_i | input | VEC_W | Vector sent in the delivery |
| eoi_valid_i | input | 1 | EOI event present |
| eoi_dest_i | input | DEST_W | Destination that sent the EOI |
| eoi_vector_i | input | VEC_W | Vector named by the EOI |
| sync_valid_i | input | 1 | Per-destination resync present |
| sync_dest_i | input | DEST_W | Destination being resynced |
| sync_pending_i | input | 1 | Live pending state of that destination |
| pin_vector_i | input | VEC_W | Vector currently programmed for the pin |
| live_pend_i | input | NUM_DEST | Live pending state of every destination, used by a rebuild |
| coalesced_o | output | 1 | Current assertion is coalesced |
| pending_o | output | CNT_W | Number of acknowledgements still owed |

## Verification
A wrong destination bit or a wrong stored vector does not show at once. It shows later, when an EOI from that destination fails to lower `pending_o`, or lowers it when it should not, one cycle after the EOI. A wrong count shows on `pending_o` in the cycle after the event that caused it, and `coalesced_o` changes with it. Because of this, the reference model is compared every cycle, and the stimulus sends EOIs to every destination it has touched, including stale, mismatched and cleared ones.

// File: rtl/coal_eoi_pkg.sv
package coal_eoi_pkg;

  localparam int MAX_DEST = 32;

  // number of set bits in a destination map (maps up to MAX_DEST wide)
  function automatic int unsigned ones_count(input logic [MAX_DEST-1:0] map);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_DEST; i++) n += int'(map[i]);
    return n;
  endfunction

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_CLEAR = 3'd1,
    EV_DLV   = 3'd2,
    EV_EOI   = 3'd3,
    EV_SYNC  = 3'd4
  } ev_sel_e;

endpackage

// File: rtl/coal_eoi_vecbank.sv
module coal_eoi_vecbank #(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DEST-1:0] ld_mask,
  input  logic [VEC_W-1:0]    ld_vec,
  input  logic [DEST_W-1:0]   rd_idx,
  output logic [VEC_W-1:0]    rd_vec
);
  logic [VEC_W-1:0] slot [NUM_DEST];

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot[d] <= '0;
      else if (ld_mask[d]) slot[d] <= ld_vec;
    end
  end

  always_comb begin
    rd_vec = '0;
    for (int d = 0; d < NUM_DEST; d++)
      if (DEST_W'(d) == rd_idx) rd_vec = slot[d];
  end
endmodule

// File: rtl/coal_eoi_decide.sv
module coal_eoi_decide
  import coal_eoi_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int CNT_W   = $clog2(NUM_DEST + 1),
  localparam int RES_W   = CNT_W + 1
) (
  input  logic                clr_i,
  input  logic                dlv_valid_i,
  input  logic [RES_W-1:0]    dlv_result_i,
  input  logic [NUM_DEST-1:0] dlv_accept_i,
  input  logic [VEC_W-1:0]    dlv_vector_i,
  input  logic                eoi_valid_i,
  input  logic [DEST_W-1:0]   eoi_dest_i,
  input  logic [VEC_W-1:0]    eoi_vector_i,
  input  logic [VEC_W-1:0]    eoi_stored_vec,
  input  logic                sync_valid_i,
  input  logic [DEST_W-1:0]   sync_dest_i,
  input  logic                sync_pending_i,
  input  logic [VEC_W-1:0]    pin_vector_i,
  input  logic [NUM_DEST-1:0] live_pend_i,
  input  logic [NUM_DEST-1:0] map_q,
  input  logic [CNT_W-1:0]    cnt_q,
  output logic [NUM_DEST-1:0] map_d,
  output logic [CNT_W-1:0]    cnt_d,
  output logic [NUM_DEST-1:0] vec_ld_mask,
  output logic [VEC_W-1:0]    vec_ld_val,
  output ev_sel_e             ev_sel,
  output logic                ev_eoi_hit,
  output logic                ev_sync_set,
  output logic                ev_sync_clr,
  output logic                ev_rebuild
);
  logic eoi_bit, sync_bit, dlv_fail, want_dec;

  assign eoi_bit  = (int'(eoi_dest_i) < NUM_DEST) && map_q[eoi_dest_i];
  assign sync_bit = (int'(sync_dest_i) < NUM_DEST) && map_q[sync_dest_i];
  assign dlv_fail = dlv_result_i[RES_W-1];

  always_comb begin
    if (clr_i)             ev_sel = EV_CLEAR;
    else if (dlv_valid_i)  ev_sel = EV_DLV;
    else if (eoi_valid_i)  ev_sel = EV_EOI;
    else if (sync_valid_i) ev_sel = EV_SYNC;
    else                   ev_sel = EV_NONE;
  end

  assign ev_eoi_hit  = (ev_sel == EV_EOI) && eoi_bit && (eoi_stored_vec == eoi_vector_i);
  assign ev_sync_set = (ev_sel == EV_SYNC) && (int'(sync_dest_i) < NUM_DEST)
                       && sync_pending_i && !sync_bit;
  assign ev_sync_clr = (ev_sel == EV_SYNC) && !sync_pending_i && sync_bit;
  assign want_dec    = ev_eoi_hit || ev_sync_clr;
  assign ev_rebuild  = want_dec && (cnt_q == '0);

  always_comb begin
    map_d       = map_q;
    cnt_d       = cnt_q;
    vec_ld_mask = '0;
    vec_ld_val  = pin_vector_i;
    if (ev_sel == EV_CLEAR) begin
      map_d = '0;
      cnt_d = '0;
    end else if (ev_sel == EV_DLV) begin
      map_d       = dlv_fail ? '0 : dlv_accept_i;
      cnt_d       = dlv_fail ? '0 : dlv_result_i[CNT_W-1:0];
      vec_ld_mask = dlv_fail ? '0 : dlv_accept_i;
      vec_ld_val  = dlv_vector_i;
    end else if (ev_rebuild) begin
      map_d       = live_pend_i;
      cnt_d       = CNT_W'(ones_count(MAX_DEST'(live_pend_i)));
      vec_ld_mask = live_pend_i;
    end else if (ev_eoi_hit) begin
      map_d[eoi_dest_i] = 1'b0;
      cnt_d             = cnt_q - 1'b1;
    end else if (ev_sync_clr) begin
      map_d[sync_dest_i] = 1'b0;
      cnt_d              = cnt_q - 1'b1;
    end else if (ev_sync_set) begin
      map_d[sync_dest_i]       = 1'b1;
      cnt_d                    = cnt_q + 1'b1;
      vec_ld_mask[sync_dest_i] = 1'b1;
    end
  end
endmodule

// File: rtl/coal_eoi_tracker.sv
module coal_eoi_tracker
  import coal_eoi_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int CNT_W   = $clog2(NUM_DEST + 1),
  localparam int RES_W   = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_assert_i,
  input  logic                clr_i,
  input  logic                dlv_valid_i,
  input  logic [RES_W-1:0]    dlv_result_i,
  input  logic [NUM_DEST-1:0] dlv_accept_i,
  input  logic [VEC_W-1:0]    dlv_vector_i,
  input  logic                eoi_valid_i,
  input  logic [DEST_W-1:0]   eoi_dest_i,
  input  logic [VEC_W-1:0]    eoi_vector_i,
  input  logic                sync_valid_i,
  input  logic [DEST_W-1:0]   sync_dest_i,
  input  logic                sync_pending_i,
  input  logic [VEC_W-1:0]    pin_vector_i,
  input  logic [NUM_DEST-1:0] live_pend_i,
  output logic                coalesced_o,
  output logic [CNT_W-1:0]    pending_o
);
  logic [NUM_DEST-1:0] map_q, map_d, vec_ld_mask;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [VEC_W-1:0]    vec_ld_val, eoi_stored_vec;
  ev_sel_e             ev_sel;
  logic                ev_eoi_hit, ev_sync_set, ev_sync_clr, ev_rebuild;

  coal_eoi_vecbank #(.NUM_DEST(NUM_DEST), .VEC_W(VEC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld_mask(vec_ld_mask), .ld_vec(vec_ld_val),
    .rd_idx(eoi_dest_i), .rd_vec(eoi_stored_vec)
  );

  coal_eoi_decide #(.NUM_DEST(NUM_DEST), .VEC_W(VEC_W)) u_decide (
    .clr_i(clr_i), .dlv_valid_i(dlv_valid_i), .dlv_result_i(dlv_result_i),
    .dlv_accept_i(dlv_accept_i), .dlv_vector_i(dlv_vector_i),
    .eoi_valid_i(eoi_valid_i), .eoi_dest_i(eoi_dest_i), .eoi_vector_i(eoi_vector_i),
    .eoi_stored_vec(eoi_stored_vec), .sync_valid_i(sync_valid_i),
    .sync_dest_i(sync_dest_i), .sync_pending_i(sync_pending_i),
    .pin_vector_i(pin_vector_i), .live_pend_i(live_pend_i),
    .map_q(map_q), .cnt_q(cnt_q), .map_d(map_d), .cnt_d(cnt_d),
    .vec_ld_mask(vec_ld_mask), .vec_ld_val(vec_ld_val), .ev_sel(ev_sel),
    .ev_eoi_hit(ev_eoi_hit), .ev_sync_set(ev_sync_set),
    .ev_sync_clr(ev_sync_clr), .ev_rebuild(ev_rebuild)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      cnt_q <= '0;
    end else begin
      map_q <= map_d;
      cnt_q <= cnt_d;
    end
  end

  assign pending_o   = cnt_q;
  assign coalesced_o = pin_assert_i && (cnt_q != '0);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pending_o == '0));

  // R2
  fail_dlv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && dlv_valid_i && dlv_result_i[RES_W-1]) |=> (pending_o == '0));

  // R3
  eoi_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eoi_hit && !ev_rebuild) |=> (pending_o == $past(pending_o) - 1'b1));

  // R8
  sync_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync_set |=> (pending_o == $past(pending_o) + 1'b1));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == '0 && ev_sel != EV_DLV && !ev_rebuild && !ev_sync_set)
      |=> (pending_o == '0));

  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_eoi_hit, ev_sync_set, ev_sync_clr}));
endmodule

// File: tb/coal_eoi_tracker_bench.sv
module coal_eoi_tracker_bench;
  localparam int ND = 8;

  logic clk = 0, rst_n = 0;
  logic pin_assert_i = 0, clr_i = 0, dlv_valid_i = 0, eoi_valid_i = 0;
  logic sync_valid_i = 0, sync_pending_i = 0;
  logic [4:0] dlv_result_i = '0;
  logic [7:0] dlv_accept_i = '0, dlv_vector_i = '0, eoi_vector_i = '0;
  logic [7:0] pin_vector_i = '0, live_pend_i = '0;
  logic [2:0] eoi_dest_i = '0, sync_dest_i = '0;
  logic coalesced_o;
  logic [3:0] pending_o;

  coal_eoi_tracker u_coal_eoi_tracker (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural reference: owed count, owed flags and recorded vectors
  int m_cnt = 0;
  bit m_owed[ND];
  int m_vec[ND];

  task automatic m_rebuild();
    m_cnt = 0;
    for (int i = 0; i < ND; i++) begin
      m_owed[i] = live_pend_i[i];
      if (live_pend_i[i]) begin m_vec[i] = pin_vector_i; m_cnt++; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      foreach (m_owed[i]) begin m_owed[i] = 0; m_vec[i] = 0; end
    end else if (clr_i) begin
      m_cnt = 0;
      foreach (m_owed[i]) m_owed[i] = 0;
    end else if (dlv_valid_i) begin
      int r;
      r = $signed(dlv_result_i);
      if (r < 0) begin
        m_cnt = 0;
        foreach (m_owed[i]) m_owed[i] = 0;
      end else begin
        m_cnt = r;
        foreach (m_owed[i]) begin
          m_owed[i] = dlv_accept_i[i];
          if (dlv_accept_i[i]) m_vec[i] = dlv_vector_i;
        end
      end
    end else if (eoi_valid_i) begin
      int d;
      d = eoi_dest_i;
      if (m_owed[d] && m_vec[d] == int'(eoi_vector_i)) begin
        if (m_cnt == 0) m_rebuild();
        else begin m_owed[d] = 0; m_cnt--; end
      end
    end else if (sync_valid_i) begin
      int d;
      d = sync_dest_i;
      if (sync_pending_i && !m_owed[d]) begin
        m_owed[d] = 1; m_vec[d] = pin_vector_i; m_cnt++;
      end else if (!sync_pending_i && m_owed[d]) begin
        if (m_cnt == 0) m_rebuild();
        else begin m_owed[d] = 0; m_cnt--; end
      end
    end
  end

  // compare midway through the low phase, when the inputs are stable
  always @(negedge clk) begin
    #5;
    if (!done) begin
      bit exp_c;
      exp_c = pin_assert_i && (m_cnt > 0);
      checks++;
      if (int'(pending_o) != m_cnt) begin
        fails++;
        $display("FAIL %s pending actual=%0d expected=%0d", cur_req, pending_o, m_cnt);
      end
      checks++;
      if (coalesced_o != exp_c) begin
        fails++;
        $display("FAIL %s coalesced actual=%0d expected=%0d", cur_req, coalesced_o, exp_c);
      end
    end
  end

  task automatic idle();
    clr_i = 0; dlv_valid_i = 0; eoi_valid_i = 0; sync_valid_i = 0;
  endtask

  task automatic cyc();
    @(negedge clk); idle();
  endtask

  task automatic deliver(string req, int res, logic [7:0] acc, logic [7:0] v);
    @(negedge clk); idle(); cur_req = req;
    dlv_valid_i = 1; dlv_result_i = 5'(res); dlv_accept_i = acc; dlv_vector_i = v;
    cyc();
  endtask

  task automatic eoi(string req, int d, logic [7:0] v);
    @(negedge clk); idle(); cur_req = req;
    eoi_valid_i = 1; eoi_dest_i = 3'(d); eoi_vector_i = v;
    cyc();
  endtask

  task automatic resync(string req, int d, bit p);
    @(negedge clk); idle(); cur_req = req;
    sync_valid_i = 1; sync_dest_i = 3'(d); sync_pending_i = p;
    cyc();
  endtask

  initial begin
    pin_assert_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(); // R11: reset state, assertion not coalesced
    deliver("R2", 3, 8'b0010_0101, 8'h41);   // R1 coalesced while owed
    eoi("R5", 1, 8'h41);                     // R5 bit clear ignored
    eoi("R4", 0, 8'h42);                     // R4 vector mismatch ignored
    eoi("R3", 0, 8'h41);                     // R3 -> 2
    eoi("R5", 0, 8'h41);                     // R5 already cleared
    pin_vector_i = 8'h60;
    resync("R8", 3, 1);                      // R8 -> 3
    resync("R8", 3, 1);                      // R8 agreeing resync, no change
    resync("R9", 2, 0);                      // R9 -> 2
    resync("R9", 4, 0);                      // R9 bit clear, no change
    eoi("R3", 5, 8'h41);
    eoi("R3", 3, 8'h60);                     // R3 -> 0, R1 no longer coalesced
    deliver("R2", 4, 8'h0F, 8'h20);
    deliver("R2", -1, 8'hFF, 8'h21);         // R2 failure -> 0
    eoi("R5", 0, 8'h21);
    // R6: count falls short of the map, then underflow triggers a rebuild
    deliver("R6", 1, 8'b0001_0010, 8'h33);
    eoi("R6", 1, 8'h33);
    live_pend_i = 8'b1100_0000; pin_vector_i = 8'h55;
    eoi("R6", 4, 8'h33);                     // rebuild -> 2
    eoi("R6", 6, 8'h55);                     // -> 1
    deliver("R6", 0, 8'b0000_1000, 8'h10);
    live_pend_i = 8'b0000_0111; pin_vector_i = 8'h77;
    resync("R6", 3, 0);                      // resync-clear at 0 -> rebuild 3
    @(negedge clk); cur_req = "R7"; clr_i = 1; cyc();  // R7
    eoi("R7", 0, 8'h77);                     // R7 map cleared too
    // R10 priorities
    @(negedge clk); cur_req = "R10"; clr_i = 1; dlv_valid_i = 1;
    dlv_result_i = 5'd2; dlv_accept_i = 8'h03; dlv_vector_i = 8'h11; cyc();
    @(negedge clk); cur_req = "R10"; dlv_valid_i = 1; dlv_result_i = 5'd2;
    dlv_accept_i = 8'h03; dlv_vector_i = 8'h11; eoi_valid_i = 1;
    eoi_dest_i = 3'd0; eoi_vector_i = 8'h11; cyc();
    @(negedge clk); cur_req = "R10"; eoi_valid_i = 1; eoi_dest_i = 3'd0;
    eoi_vector_i = 8'h11; sync_valid_i = 1; sync_dest_i = 3'd1; sync_pending_i = 0; cyc();
    pin_assert_i = 0; cur_req = "R1"; cyc();
    // mixed stimulus
    for (int k = 0; k < 600; k++) begin
      int sel;
      @(negedge clk); idle();
      cur_req = "R10";
      pin_assert_i   = 1'($urandom_range(0, 1));
      live_pend_i    = 8'($urandom);
      pin_vector_i   = 8'($urandom_range(1, 3));
      sel = $urandom_range(0, 19);
      clr_i          = (sel == 0);
      dlv_valid_i    = (sel < 3);
      dlv_result_i   = 5'($urandom_range(0, 7) - 1);
      dlv_accept_i   = 8'($urandom);
      dlv_vector_i   = 8'($urandom_range(1, 3));
      eoi_valid_i    = (sel > 1) && (sel < 12);
      eoi_dest_i     = 3'($urandom);
      eoi_vector_i   = 8'($urandom_range(1, 3));
      sync_valid_i   = (sel > 8);
      sync_dest_i    = 3'($urandom);
      sync_pending_i = 1'($urandom_range(0, 1));
      if (m_cnt > 12) begin sync_valid_i = 0; clr_i = 1; end
    end
    cyc(); cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule